// File: doc/BRIEF.md
# Configurable Two-Plane Sum-of-Products Array

This block computes a set of Boolean functions from a small input vector. Both of its planes are set at run time. Each product term in the first plane ANDs any chosen mix of input literals. Every input offers two literals to every term: its true form and its complemented form. The second plane lets each output OR together any subset of the shared pool of product terms. A single term can therefore serve several outputs.

Each output then passes through an inversion stage that can be switched on. This lets a function be built as the complement of a sum of products. It also lets that function reuse terms that other outputs already use. No output feeds back into the first plane. Building logic with more than two levels needs wiring outside the block.

The configuration is a single word that enters serially, one bit per clock, while the shift enable is high. The word stays fixed once the enable drops. The data path from the inputs to the outputs contains no registers. The pool of product terms is a hard limit: a set of functions that needs more distinct terms than the pool holds cannot be mapped.

Top module: `pla_array`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the whole configuration word. With the word cleared, both outputs are 0 for every input value.
- R2: While cfg_shift is high, each rising clock edge shifts the word left by one place and puts cfg_din into bit 0. The first bit sent therefore ends up most significant. The word is 34 bits, laid out from the top down: the AND field is bits 33..10, the OR field is bits 9..2 and the polarity field is bits 1..0.
- R3: While cfg_shift is low, the word holds its value and cfg_din has no effect on it or on the outputs.
- R4: Inside the AND field, term t (0..3) uses field bits 6t+5..6t. Bit 6t+2i connects the true literal of in_vec[i], and bit 6t+2i+1 connects its complement. The term is the AND of the literals connected to it.
- R5: A term with no literal connected evaluates to 0. A term connected to both forms of the same input is also always 0.
- R6: Inside the OR field, output o uses field bits 4o+3..4o, and bit 4o+t connects term t. Any term may feed either output, including both at once.
- R7: An output with no term connected has a sum of 0 before its inversion stage.
- R8: Polarity bit o set to 1 inverts output o after its sum. Set to 0, it passes the sum through unchanged.
- R9: The outputs follow in_vec with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration shift chain |
| rst_n | input | 1 | Asynchronous active-low reset; clears the configuration |
| cfg_shift | input | 1 | Shift enable for serial configuration |
| cfg_din | input | 1 | Serial configuration bit, most significant first |
| in_vec | input | 3 | Logic inputs |
| out_vec | output | 2 | Function outputs after the polarity stage |

## Verification
A bit that is wrong in the configuration word shows at the ports in the same cycle. Only some input combinations reveal it, because a bad literal bit changes a product term only for inputs that tell the connected literal apart from the intended one. For that reason every configuration is swept over all eight input values. A chain that shifts in the wrong direction, or that keeps shifting while it should hold, corrupts the fields at once. In that case several input values show wrong outputs right after the load.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic { LIT_TRUE = 1'b0, LIT_COMP = 1'b1 } lit_form_e;

  function automatic int lits_per_term(input int n_in);
    return 2 * n_in;
  endfunction

  function automatic int lit_index(input int in_idx, input lit_form_e form);
    return 2 * in_idx + ((form == LIT_COMP) ? 1 : 0);
  endfunction

  function automatic int cfg_width(input int n_in, input int n_out, input int n_term);
    return n_term * lits_per_term(n_in) + n_out * n_term + n_out;
  endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);

  logic [W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (shift_en) begin
      chain_q <= {chain_q[W-2:0], din};
    end
  end

  assign word = chain_q;

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  localparam int LPT   = 2 * N_IN,
  localparam int AND_W = N_TERM * LPT
) (
  input  logic [AND_W-1:0]  and_cfg,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_TERM-1:0] term_vec
);

  logic [LPT-1:0] lit_val;

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_lit
    assign lit_val[lit_index(gi, LIT_TRUE)] = in_vec[gi];
    assign lit_val[lit_index(gi, LIT_COMP)] = ~in_vec[gi];
  end

  for (genvar gt = 0; gt < N_TERM; gt++) begin : g_term
    logic [LPT-1:0] conn;
    logic           any_conn;
    logic           all_true;
    assign conn         = and_cfg[gt*LPT +: LPT];
    assign any_conn     = |conn;
    assign all_true     = &(~conn | lit_val);
    assign term_vec[gt] = any_conn & all_true;
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  localparam int OR_W  = N_OUT * N_TERM
) (
  input  logic [OR_W-1:0]   or_cfg,
  input  logic [N_OUT-1:0]  pol_cfg,
  input  logic [N_TERM-1:0] term_vec,
  output logic [N_OUT-1:0]  sum_vec,
  output logic [N_OUT-1:0]  out_vec
);

  for (genvar go = 0; go < N_OUT; go++) begin : g_out
    logic [N_TERM-1:0] sel;
    assign sel         = or_cfg[go*N_TERM +: N_TERM];
    assign sum_vec[go] = |(sel & term_vec);
    assign out_vec[go] = sum_vec[go] ^ pol_cfg[go];
  end

endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_OUT  = 2,
  parameter int N_TERM = 4,
  localparam int AND_W = N_TERM * lits_per_term(N_IN),
  localparam int OR_W  = N_OUT * N_TERM,
  localparam int CFG_W = cfg_width(N_IN, N_OUT, N_TERM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_shift,
  input  logic             cfg_din,
  input  logic [N_IN-1:0]  in_vec,
  output logic [N_OUT-1:0] out_vec
);

  logic [CFG_W-1:0]  cfg_word;
  logic [AND_W-1:0]  and_cfg;
  logic [OR_W-1:0]   or_cfg;
  logic [N_OUT-1:0]  pol_cfg;
  logic [N_TERM-1:0] term_vec;
  logic [N_OUT-1:0]  sum_vec;

  pla_cfg_chain #(.W(CFG_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_shift),
    .din      (cfg_din),
    .word     (cfg_word)
  );

  assign pol_cfg = cfg_word[N_OUT-1:0];
  assign or_cfg  = cfg_word[N_OUT +: OR_W];
  assign and_cfg = cfg_word[N_OUT+OR_W +: AND_W];

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .and_cfg  (and_cfg),
    .in_vec   (in_vec),
    .term_vec (term_vec)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .or_cfg   (or_cfg),
    .pol_cfg  (pol_cfg),
    .term_vec (term_vec),
    .sum_vec  (sum_vec),
    .out_vec  (out_vec)
  );

endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int N_IN   = 3,
  parameter int N_OUT  = 2,
  parameter int N_TERM = 4,
  localparam int LPT   = 2 * N_IN,
  localparam int AND_W = N_TERM * LPT,
  localparam int OR_W  = N_OUT * N_TERM,
  localparam int CFG_W = AND_W + OR_W + N_OUT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_shift,
  input logic              cfg_din,
  input logic [N_IN-1:0]   in_vec,
  input logic [CFG_W-1:0]  cfg_word,
  input logic [N_TERM-1:0] term_vec,
  input logic [N_OUT-1:0]  sum_vec,
  input logic [N_OUT-1:0]  out_vec
);

  logic [LPT-1:0] litv;
  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      litv[2*i]   = in_vec[i];
      litv[2*i+1] = !in_vec[i];
    end
  end

  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shift |=> (cfg_word[0] == $past(cfg_din)) &&
                  (cfg_word[CFG_W-1:1] == $past(cfg_word[CFG_W-2:0])));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_shift |=> $stable(cfg_word));

  for (genvar gt = 0; gt < N_TERM; gt++) begin : g_tchk
    logic [LPT-1:0] conn;
    assign conn = cfg_word[N_OUT+OR_W+gt*LPT +: LPT];

    p_term_sound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      term_vec[gt] |-> ((conn != '0) && ((conn & ~litv) == '0)));

    p_empty_term_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (conn == '0) |-> !term_vec[gt]);
  end

  for (genvar go = 0; go < N_OUT; go++) begin : g_ochk
    p_empty_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_word[N_OUT+go*N_TERM +: N_TERM] == '0) |->
        (!sum_vec[go] && (out_vec[go] == cfg_word[go])));
  end

endmodule

bind pla_array pla_array_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_shift(cfg_shift),
  .cfg_din  (cfg_din),
  .in_vec   (in_vec),
  .cfg_word (cfg_word),
  .term_vec (term_vec),
  .sum_vec  (sum_vec),
  .out_vec  (out_vec)
);

// File: tb/pla_array_bench.sv
module pla_array_bench;
  localparam int CLK_P = 10;
  localparam int NI = 3;
  localparam int NO = 2;
  localparam int NT = 4;
  localparam int AW = NT * 2 * NI;
  localparam int OW = NO * NT;
  localparam int W  = AW + OW + NO;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_shift = 1'b0;
  logic          cfg_din = 1'b0;
  logic [NI-1:0] in_vec = '0;
  logic [NO-1:0] out_vec;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pla_array u_pla_array (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
    .in_vec(in_vec), .out_vec(out_vec)
  );

  function automatic int and_bit(int t, int i, int comp);
    return NO + OW + t*2*NI + 2*i + comp;
  endfunction
  function automatic int or_bit(int o, int t);
    return NO + o*NT + t;
  endfunction

  function automatic logic [NO-1:0] model(logic [W-1:0] w, logic [NI-1:0] x);
    logic [NO-1:0] r;
    for (int o = 0; o < NO; o++) begin
      logic s;
      s = 1'b0;
      for (int t = 0; t < NT; t++) begin
        if (w[or_bit(o, t)]) begin
          logic p;
          int n;
          p = 1'b1;
          n = 0;
          for (int i = 0; i < NI; i++) begin
            if (w[and_bit(t, i, 0)]) begin n++; if (!x[i]) p = 1'b0; end
            if (w[and_bit(t, i, 1)]) begin n++; if (x[i])  p = 1'b0; end
          end
          if (n == 0) p = 1'b0;
          s = s | p;
        end
      end
      r[o] = s ^ w[o];
    end
    return r;
  endfunction

  task automatic check(logic [NO-1:0] exp, string req);
    total++;
    if (out_vec !== exp) begin
      bad++;
      $display("FAIL %s in=%b actual=%b expected=%b", req, in_vec, out_vec, exp);
    end
  endtask

  task automatic load(logic [W-1:0] w);
    for (int b = W-1; b >= 0; b--) begin
      @(negedge clk);
      cfg_shift = 1'b1;
      cfg_din = w[b];
    end
    @(negedge clk);
    cfg_shift = 1'b0;
    cfg_din = 1'b0;
  endtask

  task automatic sweep(logic [W-1:0] w, string req);
    for (int v = 0; v < (1 << NI); v++) begin
      in_vec = v[NI-1:0];
      #1;
      check(model(w, in_vec), req);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] w;
    logic [NO-1:0] held;
    logic [63:0] rs;

    repeat (3) @(negedge clk);
    // R1: cleared configuration gives 0 everywhere
    for (int v = 0; v < 8; v++) begin
      in_vec = v[NI-1:0]; #1; check(2'b00, "R1");
    end
    rst_n = 1'b1;

    // Main: F1 = AB+BC+AC, F2 = ~(AB + A'B') sharing AB; A=in[2],B=in[1],C=in[0]
    w = '0;
    w[and_bit(0,2,0)] = 1; w[and_bit(0,1,0)] = 1;
    w[and_bit(1,1,0)] = 1; w[and_bit(1,0,0)] = 1;
    w[and_bit(2,2,0)] = 1; w[and_bit(2,0,0)] = 1;
    w[and_bit(3,2,1)] = 1; w[and_bit(3,1,1)] = 1;
    w[or_bit(0,0)] = 1; w[or_bit(0,1)] = 1; w[or_bit(0,2)] = 1;
    w[or_bit(1,0)] = 1; w[or_bit(1,3)] = 1;
    w[1] = 1;
    load(w);
    for (int v = 0; v < 8; v++) begin
      int a, b, c;
      logic [NO-1:0] e;
      a = (v >> 2) & 1; b = (v >> 1) & 1; c = v & 1;
      e[0] = ((a + b + c) >= 2);
      e[1] = (a != b);
      in_vec = v[NI-1:0];
      #1;
      check(e, "R4 R6 R8 R9 shared-term majority/xor");
    end

    // R3: cfg_din toggling with shift low leaves outputs unchanged
    in_vec = 3'b110; #1; held = out_vec;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); cfg_din = ~cfg_din;
    end
    #1; check(held, "R3 hold");
    sweep(w, "R3 hold sweep");

    // R2: one extra shift moves the word left and inserts the new bit
    @(negedge clk); cfg_shift = 1'b1; cfg_din = 1'b1;
    @(negedge clk); cfg_shift = 1'b0; cfg_din = 1'b0;
    w = {w[W-2:0], 1'b1};
    sweep(w, "R2 shift order");

    // R5: empty terms are 0 even when selected; inverted gives 1
    w = '0;
    for (int t = 0; t < NT; t++) begin w[or_bit(0,t)] = 1; w[or_bit(1,t)] = 1; end
    w[0] = 1;
    load(w);
    for (int v = 0; v < 8; v++) begin
      in_vec = v[NI-1:0]; #1; check(2'b01, "R5 empty term");
    end

    // R5: contradictory literal pair on term 2 is always 0
    w = '0;
    w[and_bit(2,1,0)] = 1; w[and_bit(2,1,1)] = 1;
    w[or_bit(1,2)] = 1;
    load(w);
    for (int v = 0; v < 8; v++) begin
      in_vec = v[NI-1:0]; #1; check(2'b00, "R5 contradiction");
    end

    // R7 R8: no term connected, both inverted -> both 1
    w = '0; w[0] = 1; w[1] = 1;
    load(w);
    for (int v = 0; v < 8; v++) begin
      in_vec = v[NI-1:0]; #1; check(2'b11, "R7 empty output");
    end

    // Pseudo-random configurations against the arithmetic model
    rs = 64'h9E3779B97F4A7C15;
    for (int n = 0; n < 24; n++) begin
      rs ^= rs << 13; rs ^= rs >> 7; rs ^= rs << 17;
      w = rs[W-1:0];
      load(w);
      sweep(w, "R2 R4 R6 R8 random");
    end

    // R1: reset in mid-run clears the configuration at once
    @(negedge clk); rst_n = 1'b0; #1;
    sweep('0, "R1 mid-run reset");
    @(negedge clk); rst_n = 1'b1;
    #1; check(2'b00, "R1 after release");

    finish_run();
  end
endmodule